// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block derives audio sample strobes from two free-running master-rate enables, one belonging to the 44.1 kHz family and one to the 48 kHz family. Each output channel (channel 0 for playback, channel 1 for record) has its own family selection and its own rate word. The rate word carries an increment and an encoded modulus. On every enable of the chosen family the channel adds the increment to a private accumulator. When the sum reaches the modulus, the channel removes one modulus from the sum and raises its strobe for one clock. The mean strobe rate is therefore master × inc / mod.

Software normally programs inc = 4 and mod = 4 × master / rate. It picks the family whose remainder (master mod rate) is smaller, with ties going to 48 kHz, which covers rates from 8 kHz to 48 kHz. The modulus is not stored directly: the rate word holds (inc − mod − 1) truncated to 16 bits, and the block recovers mod from that field. Any write to a channel's configuration restarts that channel's accumulator, so a new rate takes effect from a known phase.

Top module: `sclk_gen`

## Requirements
- R1: After reset every channel selects the 48 kHz family, and its rate word is zero (inc 0, mod 0xFFFF), so no strobe appears whatever the enables do.
- R2: A write is taken when cfg_we is 1. cfg_sel[1] picks the channel (0 playback, 1 record). cfg_sel[0] picks the register: 0 is the family select, loaded from cfg_wdata[0] with 1 meaning the 44.1 kHz family; 1 is the 32-bit rate word.
- R3: A channel advances only on the enable of its selected family (tick_44k1 when the select is 1, tick_48k when it is 0). The other enable has no effect on its strobes.
- R4: The rate word gives inc = bits 15:0 and mod = (inc − bits 31:16 − 1) modulo 2^16.
- R5: When mod > inc, each selected enable adds inc to the accumulator. If the sum is at least mod, mod is subtracted and the strobe is 1 in the cycle after that enable; otherwise the strobe is 0. The accumulator stays below mod.
- R6: A write to either register of a channel sets that channel's accumulator to 0 and forces its strobe to 0 for that cycle, even when a selected enable is present.
- R7: A write to one channel leaves the other channel's accumulator and strobes unchanged.
- R8: When mod ≤ inc (including mod 0), every selected enable produces a strobe and the accumulator stays at 0.
- R9: A strobe never appears in a cycle that does not follow a selected enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_44k1 | input | 1 | One-cycle enable at the 44.1 kHz-family master rate |
| tick_48k | input | 1 | One-cycle enable at the 48 kHz-family master rate |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (2) | Bit 1 channel, bit 0 register (0 family select, 1 rate word) |
| cfg_wdata | input | 32 | Write data |
| sample_strobe | output | NCHAN (2) | One-cycle sample strobe per channel; bit 0 playback, bit 1 record |

## Verification
On every cycle the in-line properties check several things. A strobe must be preceded by a selected enable without a write. The accumulator must stay below the modulus whenever the modulus exceeds the increment. A write must leave a zero accumulator and a silent strobe. A small modulus must turn every enable into a strobe. Register loads must capture the write data. Exact strobe placement under interleaved enable patterns, the mapping from a requested rate to the family and modulus, and the isolation of one channel from writes to the other can only be shown by the bench. It compares each cycle against its own accumulator model across several rates and enable patterns.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int FIELD_W = 16;
  localparam int CFG_W   = 2 * FIELD_W;

  typedef struct packed {
    logic               msel;   // 1: 44.1k family, 0: 48k family
    logic [FIELD_W-1:0] inc;
    logic [FIELD_W-1:0] mod;
  } chan_cfg_t;

  // modulus is carried as (inc - mod - 1); invert that relation
  function automatic logic [FIELD_W-1:0] mod_from_field(
      input logic [FIELD_W-1:0] inc, input logic [FIELD_W-1:0] field);
    return inc - field - FIELD_W'(1);
  endfunction
endpackage

// File: rtl/sclk_cfg.sv
module sclk_cfg
  import sclk_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CH    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [CFG_W-1:0] wdata,
  output chan_cfg_t        cfg_o,
  output logic             clr_o
);
  localparam int CH_W = SEL_W - 1;

  logic             msel_q;
  logic [CFG_W-1:0] word_q;
  logic             hit;
  logic             msel_wr;
  logic             word_wr;

  assign hit     = we && (sel[SEL_W-1:1] == CH_W'(CH));
  assign msel_wr = hit && !sel[0];
  assign word_wr = hit && sel[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msel_q <= 1'b0;
      word_q <= '0;
    end else begin
      if (msel_wr) msel_q <= wdata[0];
      if (word_wr) word_q <= wdata;
    end
  end

  assign cfg_o.msel = msel_q;
  assign cfg_o.inc  = word_q[FIELD_W-1:0];
  assign cfg_o.mod  = mod_from_field(word_q[FIELD_W-1:0], word_q[CFG_W-1:FIELD_W]);
  assign clr_o      = hit;

  assert_word_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |=> (word_q == $past(wdata)));
  assert_msel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msel_wr |=> (msel_q == $past(wdata[0])));
  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_wr |=> $stable(word_q));
endmodule

// File: rtl/sclk_accum.sv
module sclk_accum
  import sclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg,
  input  logic      clr,
  input  logic      tick_hi,
  input  logic      tick_lo,
  output logic      strobe
);
  logic [FIELD_W-1:0] acc_q;
  logic [FIELD_W:0]   sum;
  logic               tick_hit;
  logic               small_mod;
  logic               wrap_hit;

  assign tick_hit  = cfg.msel ? tick_hi : tick_lo;
  assign small_mod = (cfg.mod <= cfg.inc);
  assign sum       = {1'b0, acc_q} + {1'b0, cfg.inc};
  assign wrap_hit  = small_mod || (sum >= {1'b0, cfg.mod});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      strobe <= 1'b0;
    end else if (clr) begin
      acc_q  <= '0;
      strobe <= 1'b0;
    end else if (tick_hit) begin
      strobe <= wrap_hit;
      if (small_mod)     acc_q <= '0;
      else if (wrap_hit) acc_q <= FIELD_W'(sum - {1'b0, cfg.mod});
      else               acc_q <= FIELD_W'(sum);
    end else begin
      strobe <= 1'b0;
    end
  end

  assert_strobe_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(tick_hit && !clr));
  assert_acc_below_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !small_mod |-> (acc_q < cfg.mod));
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && !strobe));
  assert_small_mod_every_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (small_mod && tick_hit && !clr) |=> (strobe && acc_q == '0));
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int NCHAN = 2,
  parameter int SEL_W = $clog2(NCHAN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_44k1,
  input  logic             tick_48k,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [NCHAN-1:0] sample_strobe
);
  chan_cfg_t      ch_cfg [NCHAN];
  logic [NCHAN-1:0] ch_clr;

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    sclk_cfg #(.SEL_W(SEL_W), .CH(g)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .sel   (cfg_sel),
      .wdata (cfg_wdata),
      .cfg_o (ch_cfg[g]),
      .clr_o (ch_clr[g])
    );
    sclk_accum u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (ch_cfg[g]),
      .clr     (ch_clr[g]),
      .tick_hi (tick_44k1),
      .tick_lo (tick_48k),
      .strobe  (sample_strobe[g])
    );
  end

  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_clr));
endmodule

// File: tb/sclk_gen_test.sv
module sclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        t44, t48, we;
  logic [1:0]  sel;
  logic [31:0] wd;
  logic [1:0]  strb;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];
  string cur_tag = "R1";

  int m_sel[2];
  int m_inc[2];
  int m_mod[2];
  int m_acc[2];

  always #5 clk = ~clk;

  sclk_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_44k1(t44), .tick_48k(t48),
    .cfg_we(we), .cfg_sel(sel), .cfg_wdata(wd), .sample_strobe(strb)
  );

  // monitor: compare one expected item per clock
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (strb !== it.exp) begin
        failures++;
        $display("FAIL %s strobe got=%b exp=%b at %0t", it.tag, strb, it.exp, $time);
      end
    end
  end

  // driver with reference model
  task automatic step(input bit a, input bit b, input bit w,
                      input logic [1:0] s, input logic [31:0] d);
    item_t it;
    @(negedge clk);
    t44 = a; t48 = b; we = w; sel = s; wd = d;
    for (int c = 0; c < 2; c++) begin
      bit tk;
      it.exp[c] = 1'b0;
      if (w && s[1] == c[0]) begin
        m_acc[c] = 0;
      end else begin
        tk = (m_sel[c] != 0) ? a : b;
        if (tk) begin
          if (m_mod[c] <= m_inc[c]) begin
            m_acc[c] = 0;
            it.exp[c] = 1'b1;
          end else begin
            m_acc[c] = m_acc[c] + m_inc[c];
            if (m_acc[c] >= m_mod[c]) begin
              m_acc[c] = m_acc[c] - m_mod[c];
              it.exp[c] = 1'b1;
            end
          end
        end
      end
    end
    if (w) begin
      int c;
      c = int'(s[1]);
      if (!s[0]) m_sel[c] = int'(d[0]);
      else begin
        m_inc[c] = int'(d[15:0]);
        m_mod[c] = (m_inc[c] - int'(d[31:16]) - 1 + 65536) % 65536;
      end
    end
    it.tag = cur_tag;
    sb.push_back(it);
  endtask

  task automatic run(input int n, input int pa, input int pb, input int ofs);
    for (int i = 0; i < n; i++)
      step(((i + ofs) % pa) == 0, (i % pb) == 0, 1'b0, 2'b00, 32'h0);
  endtask

  // software rate mapping restated: family by smaller remainder, ties to 48k
  task automatic prog(input int ch, input int rate, input bit t_a, input bit t_b);
    int master, md;
    logic [15:0] fld;
    master = ((44100 % rate) < (48000 % rate)) ? 44100 : 48000;
    md = (4 * master) / rate;
    fld = 16'(4 - md - 1);
    step(t_a, t_b, 1'b1, {ch[0], 1'b0}, {31'd0, master == 44100});
    step(t_a, t_b, 1'b1, {ch[0], 1'b1}, {fld, 16'd4});
  endtask

  initial begin
    #150000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_sel[c] = 0; m_inc[c] = 0; m_mod[c] = 65535; m_acc[c] = 0;
    end
    rst_n = 1'b0; t44 = 0; t48 = 0; we = 0; sel = 0; wd = 0;
    repeat (4) @(negedge clk);
    t44 = 1; t48 = 1;
    @(negedge clk);
    rst_n = 1'b1; t44 = 0; t48 = 0;
    checks++;
    if (strb !== 2'b00) begin
      failures++;
      $display("FAIL R1 reset strobe got=%b exp=00", strb);
    end
    // R1: reset configuration never strobes
    cur_tag = "R1";
    run(20, 1, 1, 0);
    // R2/R4: program playback 22050 (44.1k, mod 8), record 8000 (48k, mod 24)
    cur_tag = "R2";
    prog(0, 22050, 1, 1);
    prog(1, 8000, 1, 1);
    cur_tag = "R4";
    run(60, 1, 1, 0);
    // R3: differing enable patterns, each channel follows only its family
    cur_tag = "R3";
    run(90, 2, 3, 1);
    run(40, 1, 1000, 0);
    run(40, 1000, 1, 1);
    // R5: non-integer ratios and several rates
    cur_tag = "R5";
    prog(0, 11025, 0, 0);
    prog(1, 32000, 0, 0);
    run(120, 3, 2, 0);
    prog(0, 16000, 0, 0);
    prog(1, 7000, 0, 0);
    run(150, 1, 1, 0);
    step(0, 0, 1'b1, 2'b01, {16'hFFEE, 16'd5});  // inc 5, mod 22
    run(100, 1, 2, 0);
    // R6: writes during enables clear and silence the channel
    cur_tag = "R6";
    for (int k = 0; k < 6; k++) begin
      run(k + 2, 1, 1, 0);
      step(1, 1, 1'b1, {1'b0, k[0]}, k[0] ? {16'hFFEE, 16'd5} : 32'd1);
    end
    // R7: writes to record while playback keeps running
    cur_tag = "R7";
    for (int k = 0; k < 30; k++)
      step(1, 1, 1'b1, {1'b1, k[0]}, k[0] ? {16'hFFF3, 16'd4} : 32'd0);
    run(30, 1, 1, 0);
    // R8: modulus not above increment
    cur_tag = "R8";
    prog(0, 48000, 1, 1);
    step(0, 0, 1'b1, 2'b11, {16'h0003, 16'd4});  // mod 0
    step(0, 0, 1'b1, 2'b10, 32'd1);
    run(40, 1, 2, 0);
    step(0, 0, 1'b1, 2'b01, {16'hFFFF, 16'd7});  // inc 7, mod 7
    run(20, 2, 1, 0);
    // R9: no enables, no strobes
    cur_tag = "R9";
    run(25, 1000, 1000, 1);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule